// File: doc/BRIEF.md
# Receive Frame Length Checker

This block sits in the receive path of a bit-oriented framing receiver, after flag detection and zero-bit removal. It watches a stream of byte strobes bracketed by start-of-frame and end-of-frame markers and counts the bytes of each frame, including its check bytes. It compares that count against a programmable ceiling. A frame that stays within the ceiling ends with an ordinary end-of-message pulse. A frame that runs past the ceiling has its surplus bytes refused. The checker then closes that frame at once, in the same way as a frame the far end aborted: it gives an end-of-message pulse with the abort status set.

The ceiling is coded in units of 32 bytes. A 7-bit field `n` selects a maximum of `(n + 1) * 32` bytes, so the range is 32 to 4096 bytes. A separate enable input switches the check on or off. Both values are captured when a frame starts and stay in force until that frame ends. The data-accept output is a combinational gate that downstream storage uses as its write enable.

Top module: `rx_len_guard`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `eom_pulse` and `abort_flag` are 0. The latched enable resets to 0, and no byte is accepted before the first start of frame.
- R2: With the check enabled and `len_fld = n`, a frame of exactly `(n+1)*32` bytes has every byte accepted and ends normally.
- R3: With the check enabled, byte number `(n+1)*32 + 1` of a frame is refused (`accept` = 0). In the next cycle `eom_pulse` is 1 with `abort_flag` = 1.
- R4: After an over-length close, all later bytes of that frame are refused, and its end-of-frame marker produces no second `eom_pulse`.
- R5: A frame that ends at or under the limit gives one `eom_pulse` in the cycle after the end-of-frame marker, with `abort_flag` = 0.
- R6: With `chk_en` = 0 at start of frame, there is no length limit: every byte of a frame of any length is accepted, and the frame ends normally.
- R7: `chk_en` and `len_fld` are sampled on the start-of-frame cycle. Changes during the frame have no effect on that frame.
- R8: `accept` is high only for a byte strobe that is inside an open frame. The start-of-frame cycle counts as inside the frame. Bytes before any start of frame, or after the end-of-frame marker, are refused.
- R9: `abort_flag` holds its value between frames, is cleared in the cycle after the next start of frame, and rises together with `eom_pulse`.
- R10: Each frame produces exactly one `eom_pulse`, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| sof | input | 1 | Start of frame; may coincide with the first byte strobe |
| eof | input | 1 | End of frame; may coincide with the last byte strobe |
| chk_en | input | 1 | Length check enable, sampled at start of frame |
| len_fld | input | FLD_W | Limit code n; ceiling is (n+1)*32 bytes, sampled at start of frame |
| accept | output | 1 | Byte may be stored (combinational gate) |
| eom_pulse | output | 1 | One-cycle end-of-message pulse |
| abort_flag | output | 1 | Frame closed as aborted; valid with eom_pulse, held until next frame |

## Verification
The hardest state to reach is the boundary between the last allowed byte and the first refused byte. The refusal, the abort close and the suppressed second end marker all hinge on a single count comparison at that point. The stimulus table runs frames of exactly the limit, one byte over, and far over, at the smallest, a middle and the largest limit code, with both back-to-back and gapped byte strobes. Directed tests also change the enable and limit in the middle of a frame, and start a new frame while the abort flag from the previous frame is still set.

// File: rtl/rx_len_guard_pkg.sv
package rx_len_guard_pkg;

    // Default width of the limit code and the size of one limit unit
    localparam int FLD_W_DEF     = 7;
    localparam int UNIT_LOG2_DEF = 5;

    // Receive sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // between frames, bytes refused
        ST_RECV = 2'd1,   // frame open, bytes counted
        ST_DROP = 2'd2    // frame over length, rest discarded
    } rx_state_t;

    // End-of-message event as presented at the outputs
    typedef struct packed {
        logic eom;
        logic abort;
    } rx_evt_t;

    // Counter width needed to hold the largest ceiling
    function automatic int cnt_width(input int fld_w, input int unit_log2);
        return fld_w + unit_log2 + 1;
    endfunction

endpackage

// File: rtl/rx_len_limit.sv
module rx_len_limit #(
    parameter int FLD_W     = 7,
    parameter int UNIT_LOG2 = 5,
    parameter int CNT_W     = FLD_W + UNIT_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             chk_en,
    input  logic [FLD_W-1:0] len_fld,
    output logic             en_q,
    output logic [CNT_W-1:0] limit_q
);
    // Ceiling in bytes: (code + 1) units
    logic [CNT_W-1:0] limit_d;

    always_comb begin
        limit_d = (CNT_W'(len_fld) + CNT_W'(1)) << UNIT_LOG2;
    end

    // Captured once per frame
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            limit_q <= '0;
        end else if (sof) begin
            en_q    <= chk_en;
            limit_q <= limit_d;
        end
    end
endmodule

// File: rtl/rx_len_counter.sv
module rx_len_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             acc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Counts accepted bytes of the open frame; saturates when unchecked
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (sof) begin
            cnt <= acc ? CNT_W'(1) : '0;
        end else if (acc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rx_len_ctrl.sv
module rx_len_ctrl
    import rx_len_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sof,
    input  logic    eof,
    input  logic    byte_vld,
    input  logic    en_q,
    input  logic    at_limit,
    output logic    accept,
    output rx_evt_t evt_q
);
    rx_state_t state_q, state_d;
    logic      in_frame;
    logic      overrun;
    rx_evt_t   evt_d;

    always_comb begin
        in_frame = (state_q == ST_RECV);
        // One byte beyond the captured ceiling while checking is on
        overrun  = in_frame && !sof && byte_vld && en_q && at_limit;
        accept   = byte_vld && (sof || (in_frame && !overrun));
    end

    always_comb begin
        state_d = state_q;
        evt_d   = '{eom: 1'b0, abort: evt_q.abort};
        if (sof) begin
            evt_d.abort = 1'b0;
            if (eof) begin
                state_d   = ST_IDLE;
                evt_d.eom = 1'b1;
            end else begin
                state_d   = ST_RECV;
            end
        end else begin
            unique case (state_q)
                ST_RECV: begin
                    if (overrun) begin
                        state_d     = ST_DROP;
                        evt_d.eom   = 1'b1;
                        evt_d.abort = 1'b1;
                    end else if (eof) begin
                        state_d     = ST_IDLE;
                        evt_d.eom   = 1'b1;
                    end
                end
                ST_DROP: state_d = ST_DROP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt_q   <= '{eom: 1'b0, abort: 1'b0};
        end else begin
            state_q <= state_d;
            evt_q   <= evt_d;
        end
    end
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
    import rx_len_guard_pkg::*;
#(
    parameter int FLD_W     = FLD_W_DEF,
    parameter int UNIT_LOG2 = UNIT_LOG2_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             eof,
    input  logic             chk_en,
    input  logic [FLD_W-1:0] len_fld,
    output logic             accept,
    output logic             eom_pulse,
    output logic             abort_flag
);
    localparam int CNT_W = cnt_width(FLD_W, UNIT_LOG2);

    logic             en_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt;
    logic             at_limit;
    rx_evt_t          evt;

    rx_len_limit #(
        .FLD_W     (FLD_W),
        .UNIT_LOG2 (UNIT_LOG2),
        .CNT_W     (CNT_W)
    ) u_limit (
        .clk     (clk),
        .rst     (rst),
        .sof     (sof),
        .chk_en  (chk_en),
        .len_fld (len_fld),
        .en_q    (en_q),
        .limit_q (limit_q)
    );

    rx_len_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk (clk),
        .rst (rst),
        .sof (sof),
        .acc (accept),
        .cnt (cnt)
    );

    assign at_limit = (cnt == limit_q);

    rx_len_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sof      (sof),
        .eof      (eof),
        .byte_vld (byte_vld),
        .en_q     (en_q),
        .at_limit (at_limit),
        .accept   (accept),
        .evt_q    (evt)
    );

    assign eom_pulse  = evt.eom;
    assign abort_flag = evt.abort;
endmodule

// File: rtl/rx_len_guard_chk.sv
module rx_len_guard_chk (
    input logic clk,
    input logic rst,
    input logic byte_vld,
    input logic sof,
    input logic eof,
    input logic accept,
    input logic eom_pulse,
    input logic abort_flag
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!eom_pulse && !abort_flag));

    // R3
    abort_with_eom_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_flag) |-> eom_pulse);

    // R4
    drop_after_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_flag && !sof) |-> !accept);

    // R5
    normal_eom_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (eom_pulse && !abort_flag) |-> $past(eof));

    // R8
    accept_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> byte_vld);

    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_flag && !sof) |=> abort_flag);
endmodule

bind rx_len_guard rx_len_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .sof        (sof),
    .eof        (eof),
    .accept     (accept),
    .eom_pulse  (eom_pulse),
    .abort_flag (abort_flag)
);

// File: tb/rx_len_guard_test.sv
module rx_len_guard_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       byte_vld, sof, eof, chk_en;
    logic [6:0] len_fld;
    logic       accept, eom_pulse, abort_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_len_guard uut (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .sof        (sof),
        .eof        (eof),
        .chk_en     (chk_en),
        .len_fld    (len_fld),
        .accept     (accept),
        .eom_pulse  (eom_pulse),
        .abort_flag (abort_flag)
    );

    typedef struct packed {
        logic [6:0] fld;
        logic       en;
        int         n;
        logic       gap;
        logic       chg;
        int         exp_acc;
        logic       exp_ab;
    } vec_t;

    // fld, en, bytes, gapped, mid-frame change, expected accepted, expected abort
    localparam vec_t VECS[11] = '{
        '{7'd0,   1'b1, 32,   1'b0, 1'b0, 32,   1'b0},  // R2 exact limit
        '{7'd0,   1'b1, 33,   1'b0, 1'b0, 32,   1'b1},  // R3 one over
        '{7'd0,   1'b1, 100,  1'b0, 1'b0, 32,   1'b1},  // R4 far over
        '{7'd1,   1'b1, 64,   1'b1, 1'b0, 64,   1'b0},  // R2 gapped
        '{7'd1,   1'b1, 65,   1'b1, 1'b0, 64,   1'b1},  // R3 gapped
        '{7'd0,   1'b0, 200,  1'b0, 1'b0, 200,  1'b0},  // R6 unchecked
        '{7'd2,   1'b1, 1,    1'b0, 1'b0, 1,    1'b0},  // R5 one byte
        '{7'd127, 1'b1, 300,  1'b0, 1'b0, 300,  1'b0},  // R5 under max
        '{7'd3,   1'b1, 129,  1'b0, 1'b0, 128,  1'b1},  // R3 mid code
        '{7'd127, 1'b1, 4097, 1'b0, 1'b0, 4096, 1'b1},  // R3 largest code
        '{7'd0,   1'b1, 40,   1'b0, 1'b1, 32,   1'b1}   // R7 change ignored
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        byte_vld = 1'b0; sof = 1'b0; eof = 1'b0;
    endtask

    // Samples outputs 1 ns after a falling edge
    task automatic sample(inout int acc, inout int eoms, inout int ab);
        #1;
        if (accept) acc++;
        if (eom_pulse) begin
            eoms++;
            ab = abort_flag;
        end
    endtask

    task automatic run_frame(input vec_t v, output int acc, output int eoms, output int ab);
        acc = 0; eoms = 0; ab = -1;
        for (int i = 0; i < v.n; i++) begin
            if (v.gap && i > 0) begin
                @(negedge clk);
                idle_inputs();
                sample(acc, eoms, ab);
            end
            @(negedge clk);
            sof      = (i == 0);
            eof      = (i == v.n - 1);
            byte_vld = 1'b1;
            if (i == 0) begin
                chk_en  = v.en;
                len_fld = v.fld;
            end else if (v.chg && i == 1) begin
                chk_en  = 1'b0;
                len_fld = 7'd127;
            end
            sample(acc, eoms, ab);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle_inputs();
            sample(acc, eoms, ab);
        end
    endtask

    initial begin
        int acc, eoms, ab;
        rst = 1'b1; chk_en = 1'b1; len_fld = 7'd0;
        idle_inputs();
        repeat (3) @(negedge clk);
        #1;
        // R1 outputs quiet during reset
        check("R1 eom in reset", eom_pulse, 0);
        check("R1 abort in reset", abort_flag, 0);
        @(negedge clk);
        rst = 1'b0;

        // R8 bytes before any start of frame are refused
        acc = 0; eoms = 0; ab = -1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_vld = 1'b1; eof = (i == 5);
            sample(acc, eoms, ab);
        end
        check("R8 accepted before sof", acc, 0);
        check("R1 no eom before first frame", eoms, 0);
        @(negedge clk);
        idle_inputs();

        foreach (VECS[j]) begin
            run_frame(VECS[j], acc, eoms, ab);
            $display("vector %0d: n=%0d accepted=%0d", j, VECS[j].n, acc);
            check("R2/R3/R6/R7 accepted bytes", acc, VECS[j].exp_acc);
            check("R10/R4 eom pulses", eoms, 1);
            check("R3/R5 abort at eom", ab, int'(VECS[j].exp_ab));
        end

        // R9 abort held between frames, cleared after next sof
        repeat (5) @(negedge clk);
        #1;
        check("R9 abort held", abort_flag, 1);
        @(negedge clk);
        sof = 1'b1; chk_en = 1'b1; len_fld = 7'd0;
        #1;
        check("R9 abort still set on sof cycle", abort_flag, 1);
        @(negedge clk);
        sof = 1'b0;
        #1;
        check("R9 abort cleared after sof", abort_flag, 0);

        // R8 byte after end-of-frame refused
        @(negedge clk);
        eof = 1'b1;
        @(negedge clk);
        eof = 1'b0; byte_vld = 1'b1;
        #1;
        check("R8 byte after eof", accept, 0);
        check("R5 eom after empty frame", eom_pulse, 1);
        @(negedge clk);
        idle_inputs();
        #1;
        check("R10 eom width", eom_pulse, 0);

        // R8 byte on the sof cycle is accepted
        @(negedge clk);
        sof = 1'b1; byte_vld = 1'b1; eof = 1'b1;
        #1;
        check("R8 byte on sof", accept, 1);
        @(negedge clk);
        idle_inputs();
        #1;
        check("R5 single cycle frame eom", eom_pulse, 1);
        check("R5 single cycle frame abort", abort_flag, 0);

        // R1 reset mid-frame clears status
        run_frame(VECS[1], acc, eoms, ab);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 abort after reset", abort_flag, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule